// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit integer processor that retires one instruction on every rising clock edge. Each cycle it fetches a word at the program counter, decodes it, reads two registers, runs the arithmetic unit and picks the next program counter. In the same edge it may also write one register and one data word. Supported operations are word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an absolute jump.

Instruction storage and data storage are separate word arrays inside the block. Each array has a synchronous write and an asynchronous read. Both arrays are filled through a loading port while reset is held. A registered debug view shows the current program counter and the most recent register write. The block is meant as a compact control and datapath reference, and as a bring-up target for simple programs.

Top module: `onecycle_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears the debug write flag. While reset is high, no register write and no core data write happens.
- R2: Any instruction that is not a taken branch or a jump sets the program counter to its own address plus 4 on the next edge. The program counter stays word aligned.
- R3: Opcode 0 (bits [31:26]) is a register operation. The result goes to the register named by bits [15:11]. Funct (bits [5:0]) 0x20 adds, 0x22 subtracts, 0x24 is bitwise and, 0x25 is bitwise or, and 0x2A writes 1 when the first operand is less than the second as signed numbers (0 otherwise). The first operand comes from bits [25:21] and the second from bits [20:16].
- R4: Opcode 35 loads into the register named by bits [20:16]. The value is the data word at byte address reg[bits 25:21] plus the sign-extended bits [15:0]. The word index is that byte address shifted right by 2.
- R5: Opcode 43 stores the register named by bits [20:16] to the data word at the same computed address. It writes no register.
- R6: Opcode 4 compares the two source registers. When they are equal, the next program counter is the address plus 4 plus the sign-extended bits [15:0] shifted left by 2. Otherwise it is the address plus 4. The branch writes nothing.
- R7: Opcode 2 jumps. The next program counter is the top 4 bits of address plus 4, then bits [25:0], then two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it changes nothing and is not reported on the debug port.
- R9: An unknown opcode, or opcode 0 with an unlisted funct, writes neither a register nor data memory. The program counter advances by 4.
- R10: On the edge after an instruction writes a register, dbg_wr_valid is 1 and dbg_wr_addr and dbg_wr_data show that write. After an edge with no write, dbg_wr_valid is 0. dbg_pc always shows the current program counter.
- R11: Negative 16-bit offsets are sign extended, for load and store addresses and for backward branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Loading-port write strobe |
| prog_sel | input | 1 | Loading target: 0 instruction array, 1 data array |
| prog_addr | input | LOAD_AW | Word index for the loading port |
| prog_data | input | 32 | Word written through the loading port |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_valid | output | 1 | A register was written on the last edge |
| dbg_wr_addr | output | 5 | Register index of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The bench uses set-less-than on a negative and a positive operand. A core that compares unsigned values would return the opposite bit. It also builds store and load addresses from negative offsets, and takes a backward branch. A zero-extending core would then store to the wrong word and land on the wrong program counter. A load that targets register 0 checks that a zero-register write shows up neither on the debug port nor on later reads. An unknown opcode and an unlisted funct check that bad encodings do not fall through into an add that writes back. A not-taken branch, a taken branch and a jump catch a core that selects its next address from the opcode alone and ignores the zero flag.

// File: rtl/oc_pkg.sv
package oc_pkg;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } aluop_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_ctrl_e;

  typedef struct packed {
    logic   dst_rd;
    logic   b_imm;
    logic   wb_mem;
    logic   reg_we;
    logic   mem_we;
    logic   branch;
    logic   jump;
    aluop_e aluop;
  } ctrl_t;

endpackage

// File: rtl/oc_main_dec.sv
module oc_main_dec
  import oc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.aluop  = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_imm  = 1'b1;
        ctrl.wb_mem = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.aluop  = AOP_ADD;
      end
      OPC_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_we = 1'b1;
        ctrl.aluop  = AOP_ADD;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluop  = AOP_SUB;
      end
      OPC_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/oc_alu_dec.sv
module oc_alu_dec
  import oc_pkg::*;
(
  input  aluop_e     aluop,
  input  logic [5:0] funct,
  output alu_ctrl_e  alu_ctrl,
  output logic       op_ok
);

  always_comb begin
    alu_ctrl = ALU_ADD;
    op_ok    = 1'b1;
    case (aluop)
      AOP_ADD: alu_ctrl = ALU_ADD;
      AOP_SUB: alu_ctrl = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD: alu_ctrl = ALU_ADD;
          FN_SUB: alu_ctrl = ALU_SUB;
          FN_AND: alu_ctrl = ALU_AND;
          FN_OR:  alu_ctrl = ALU_OR;
          FN_SLT: alu_ctrl = ALU_SLT;
          default: begin
            alu_ctrl = ALU_ADD;
            op_ok    = 1'b0;
          end
        endcase
      end
      default: op_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/oc_alu.sv
module oc_alu
  import oc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctrl_e    op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RA  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RA-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [RA-1:0] raddr_a,
  input  logic [RA-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/oc_ram.sv
module oc_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/oc_next_pc.sv
module oc_next_pc #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] imm_ext,
  input  logic [W-7:0] jfield,
  input  logic         take_branch,
  input  logic         jump,
  output logic [W-1:0] next_pc
);

  logic [W-1:0] pc_plus4;
  logic [W-1:0] br_target;
  logic [W-1:0] j_target;

  assign pc_plus4  = pc + W'(4);
  assign br_target = pc_plus4 + {imm_ext[W-3:0], 2'b00};
  assign j_target  = {pc_plus4[W-1:W-4], jfield, 2'b00};

  always_comb begin
    if (jump)             next_pc = j_target;
    else if (take_branch) next_pc = br_target;
    else                  next_pc = pc_plus4;
  end

endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
  import oc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic               prog_sel,
  input  logic [LOAD_AW-1:0] prog_addr,
  input  logic [31:0]        prog_data,
  output logic [31:0]        dbg_pc,
  output logic               dbg_wr_valid,
  output logic [4:0]         dbg_wr_addr,
  output logic [31:0]        dbg_wr_data
);

  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RA   = $clog2(NREG);
  localparam int IAW  = $clog2(IMEM_WORDS);
  localparam int DAW  = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] instr;
  logic [5:0]      op;
  logic [RA-1:0]   rs, rt, rd;
  logic [15:0]     imm16;
  logic [5:0]      funct;
  logic [XLEN-1:0] imm_ext;
  ctrl_t           ctrl;
  alu_ctrl_e       alu_op;
  logic            op_ok;
  logic [XLEN-1:0] rdata_a, rdata_b, alu_b, alu_y, dm_rdata;
  logic            alu_zero;
  logic [RA-1:0]   wb_addr;
  logic [XLEN-1:0] wb_data;
  logic            rf_we, mem_we, is_jump, take_branch;
  logic            dm_we;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign imm16 = instr[15:0];
  assign funct = instr[5:0];
  assign imm_ext = {{(XLEN-16){imm16[15]}}, imm16};

  oc_ram #(.W(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (prog_we & ~prog_sel),
    .waddr (prog_addr[IAW-1:0]),
    .wdata (prog_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  oc_main_dec u_main_dec (
    .opcode (op),
    .ctrl   (ctrl)
  );

  oc_alu_dec u_alu_dec (
    .aluop    (ctrl.aluop),
    .funct    (funct),
    .alu_ctrl (alu_op),
    .op_ok    (op_ok)
  );

  oc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (rs),
    .raddr_b (rt),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
  );

  assign alu_b = ctrl.b_imm ? imm_ext : rdata_b;

  oc_alu #(.W(XLEN)) u_alu (
    .a    (rdata_a),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign mem_we   = ctrl.mem_we & ~rst;
  assign dm_we    = (prog_we & prog_sel) | mem_we;
  assign dm_waddr = prog_we ? prog_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dm_wdata = prog_we ? prog_data : rdata_b;

  oc_ram #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dm_rdata)
  );

  assign wb_addr = ctrl.dst_rd ? rd : rt;
  assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;
  assign rf_we   = ctrl.reg_we & op_ok & ~rst & (wb_addr != '0);

  assign is_jump     = ctrl.jump;
  assign take_branch = ctrl.branch & alu_zero;

  oc_next_pc #(.W(XLEN)) u_npc (
    .pc          (pc_q),
    .imm_ext     (imm_ext),
    .jfield      (instr[25:0]),
    .take_branch (take_branch),
    .jump        (is_jump),
    .next_pc     (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_wr_valid <= 1'b0;
      dbg_wr_addr  <= '0;
      dbg_wr_data  <= '0;
    end else begin
      dbg_wr_valid <= rf_we;
      dbg_wr_addr  <= wb_addr;
      dbg_wr_data  <= wb_data;
    end
  end

  assign dbg_pc = pc_q;

endmodule

// File: rtl/oc_core_chk.sv
module oc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  opcode,
  input logic        rf_we,
  input logic        mem_we,
  input logic [4:0]  wb_addr,
  input logic        is_jump,
  input logic        take_branch,
  input logic        dbg_wr_valid,
  input logic [4:0]  dbg_wr_addr
);

  p_pc_reset_r1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  p_rst_quiet_r1: assert property (@(posedge clk) rst |-> (!rf_we && !mem_we));

  p_pc_align_r2: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);

  p_pc_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (!is_jump && !take_branch) |=> pc == $past(pc) + 32'd4);

  p_store_no_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (opcode == 6'd43) |-> !rf_we);

  p_zero_reg_hidden_r8: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_valid |-> dbg_wr_addr != 5'd0);

  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (opcode != 6'd0 && opcode != 6'd2 && opcode != 6'd4 &&
     opcode != 6'd35 && opcode != 6'd43) |-> (!rf_we && !mem_we));

  p_dbg_follow_r10: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> (dbg_wr_valid && dbg_wr_addr == $past(wb_addr)));

endmodule

bind onecycle_core oc_core_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .pc           (pc_q),
  .opcode       (op),
  .rf_we        (rf_we),
  .mem_we       (mem_we),
  .wb_addr      (wb_addr),
  .is_jump      (is_jump),
  .take_branch  (take_branch),
  .dbg_wr_valid (dbg_wr_valid),
  .dbg_wr_addr  (dbg_wr_addr)
);

// File: tb/test_onecycle_core.sv
`timescale 1ns/1ps
module test_onecycle_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic        prog_sel = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_wr_valid;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  onecycle_core i_onecycle_core (
    .clk          (clk),
    .rst          (rst),
    .prog_we      (prog_we),
    .prog_sel     (prog_sel),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .dbg_pc       (dbg_pc),
    .dbg_wr_valid (dbg_wr_valid),
    .dbg_wr_addr  (dbg_wr_addr),
    .dbg_wr_data  (dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(logic [4:0] s, logic [4:0] t, logic [4:0] d, logic [5:0] fn);
    return {6'd0, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] opc, logic [4:0] s, logic [4:0] t, logic [15:0] imm);
    return {opc, s, t, imm};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(logic sel, int idx, logic [31:0] word);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = sel; prog_addr = 8'(idx); prog_data = word;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one instruction retires; sample at the following falling edge
  task automatic step(string tag, logic exp_v, logic [4:0] exp_a, logic [31:0] exp_d, logic [31:0] exp_pc);
    @(posedge clk);
    @(negedge clk);
    check({tag, " wr_valid"}, 32'(dbg_wr_valid), 32'(exp_v));
    if (exp_v) begin
      check({tag, " wr_addr"}, 32'(dbg_wr_addr), 32'(exp_a));
      check({tag, " wr_data"}, dbg_wr_data, exp_d);
    end
    check({tag, " pc"}, dbg_pc, exp_pc);
  endtask

  task automatic t_reset();
    hold_reset();
    check("R1 pc after reset", dbg_pc, 32'd0);
    check("R1 wr_valid after reset", 32'(dbg_wr_valid), 32'd0);
  endtask

  task automatic t_alu();
    hold_reset();
    load(1, 0, 32'd5);
    load(1, 1, 32'hFFFF_FFFD);
    load(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
    load(0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd4));
    load(0, 2, enc_r(5'd1, 5'd2, 5'd3, 6'h20));
    load(0, 3, enc_r(5'd1, 5'd2, 5'd4, 6'h22));
    load(0, 4, enc_r(5'd1, 5'd2, 5'd5, 6'h24));
    load(0, 5, enc_r(5'd1, 5'd2, 5'd6, 6'h25));
    load(0, 6, enc_r(5'd2, 5'd1, 5'd7, 6'h2A));
    load(0, 7, enc_r(5'd1, 5'd2, 5'd8, 6'h2A));
    release_reset();
    step("R4 load r1", 1, 5'd1, 32'd5, 32'd4);
    step("R4 load r2", 1, 5'd2, 32'hFFFF_FFFD, 32'd8);
    step("R3 add", 1, 5'd3, 32'd2, 32'd12);
    step("R3 sub", 1, 5'd4, 32'd8, 32'd16);
    step("R3 and", 1, 5'd5, 32'd5, 32'd20);
    step("R3 or", 1, 5'd6, 32'hFFFF_FFFD, 32'd24);
    step("R3 slt signed true", 1, 5'd7, 32'd1, 32'd28);
    step("R3 slt signed false R10", 1, 5'd8, 32'd0, 32'd32);
  endtask

  task automatic t_mem();
    hold_reset();
    load(1, 3, 32'h1234_5678);
    load(1, 4, 32'h0000_0020);
    load(1, 7, 32'h0000_0000);
    load(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd12));
    load(0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd16));
    load(0, 2, enc_i(6'd43, 5'd2, 5'd1, 16'hFFFC));
    load(0, 3, enc_i(6'd35, 5'd2, 5'd3, 16'hFFFC));
    release_reset();
    step("R4 load r1", 1, 5'd1, 32'h1234_5678, 32'd4);
    step("R4 load base", 1, 5'd2, 32'h20, 32'd8);
    step("R5 store no reg write", 0, 5'd0, 32'd0, 32'd12);
    step("R11 negative offset reload", 1, 5'd3, 32'h1234_5678, 32'd16);
  endtask

  task automatic t_branch();
    hold_reset();
    load(1, 0, 32'd7);
    load(1, 1, 32'd7);
    load(1, 2, 32'd9);
    load(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
    load(0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd4));
    load(0, 2, enc_i(6'd35, 5'd0, 5'd3, 16'd8));
    load(0, 3, enc_i(6'd4, 5'd1, 5'd3, 16'd5));
    load(0, 4, enc_i(6'd4, 5'd1, 5'd2, 16'd3));
    for (int k = 5; k < 8; k++) load(0, k, enc_i(6'd35, 5'd0, 5'd10, 16'd8));
    load(0, 8, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFC));
    release_reset();
    step("R6 setup r1", 1, 5'd1, 32'd7, 32'd4);
    step("R6 setup r2", 1, 5'd2, 32'd7, 32'd8);
    step("R6 setup r3", 1, 5'd3, 32'd9, 32'd12);
    step("R6 not taken", 0, 5'd0, 32'd0, 32'd16);
    step("R6 taken forward", 0, 5'd0, 32'd0, 32'd32);
    step("R11 taken backward", 0, 5'd0, 32'd0, 32'd20);
    step("R2 after backward branch", 1, 5'd10, 32'd9, 32'd24);
  endtask

  task automatic t_jump();
    hold_reset();
    load(1, 0, 32'h55);
    load(0, 0, {6'd2, 26'd6});
    for (int k = 1; k < 6; k++) load(0, k, enc_i(6'd35, 5'd0, 5'd9, 16'd0));
    load(0, 6, enc_i(6'd35, 5'd0, 5'd4, 16'd0));
    release_reset();
    step("R7 jump", 0, 5'd0, 32'd0, 32'd24);
    step("R7 jump landing", 1, 5'd4, 32'h55, 32'd28);
  endtask

  task automatic t_zero_unknown();
    hold_reset();
    load(1, 0, 32'hAB);
    load(0, 0, enc_i(6'd35, 5'd0, 5'd0, 16'd0));
    load(0, 1, enc_r(5'd0, 5'd0, 5'd5, 6'h20));
    load(0, 2, 32'hFC22_0000);
    load(0, 3, enc_r(5'd1, 5'd1, 5'd7, 6'h27));
    load(0, 4, enc_i(6'd35, 5'd0, 5'd6, 16'd0));
    release_reset();
    step("R8 write to r0 hidden", 0, 5'd0, 32'd0, 32'd4);
    step("R8 r0 reads zero", 1, 5'd5, 32'd0, 32'd8);
    step("R9 unknown opcode", 0, 5'd0, 32'd0, 32'd12);
    step("R9 unlisted funct", 0, 5'd0, 32'd0, 32'd16);
    step("R9 data intact", 1, 5'd6, 32'hAB, 32'd20);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_zero_unknown();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule